// File: doc/BRIEF.md
# Flag-Conditioned Register Move Unit

This execute-stage unit carries out conditional register moves that depend on integer condition flags. Each cycle it can take one 32-bit instruction word and two 4-bit flag groups: a narrow (32-bit result) group and a wide (64-bit result) group. It also takes the 64-bit value read from the source register. The unit checks the opcode and picks one flag group from a 3-bit select spread across the word. It then tests one of sixteen conditions against that group.

One cycle after the instruction is presented, the unit returns a register-file write request. The request carries the destination index and the data to write. The data is either the source operand or an 11-bit signed immediate widened to 64 bits. The write enable is asserted only when the condition holds. A flag-group select the unit does not recognise raises an illegal-instruction output. Words with a different opcode pass through the unit with no effect.

Top module: `flagmove_unit`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by one clock. After reset, `out_valid`, `wr_en` and `illegal` are all low.
- R2: A word belongs to the unit only when bits 31..30 are 2'b10 and bits 24..19 are 6'b101100. Any other word gives `wr_en` = 0 and `illegal` = 0.
- R3: The flag-group select is {bit18, bit12, bit11}. The value 3'b100 uses `flags_narrow` and 3'b110 uses `flags_wide`. Each flag group holds N in bit 3, Z in bit 2, V in bit 1 and C in bit 0.
- R4: Any other select value sets `illegal` to 1 and `wr_en` to 0.
- R5: The condition is in bits 17..14. Codes 0..7 test, in order: false, Z, Z|(N^V), N^V, C|Z, C, N, V.
- R6: Codes 8..15 are the logical inverses of codes 0..7, in the same order.
- R7: When bit 13 is 0, `wr_data` is `src_val`. Bits 10..5 of the word have no effect in this mode.
- R8: When bit 13 is 1, `wr_data` is bits 10..0 sign-extended to 64 bits.
- R9: `wr_idx` is bits 29..25. When that index is 0, `wr_en` stays low.
- R10: When the condition is false, `wr_en` stays low and the destination register is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present this cycle |
| instr | input | 32 | Instruction word |
| flags_narrow | input | 4 | N,Z,V,C flags from 32-bit results |
| flags_wide | input | 4 | N,Z,V,C flags from 64-bit results |
| src_val | input | 64 | Source register value |
| out_valid | output | 1 | Result valid |
| wr_en | output | 1 | Register-file write enable |
| wr_idx | output | 5 | Destination register index |
| wr_data | output | 64 | Data to write |
| illegal | output | 1 | Unrecognised flag-group select |

## Verification
The hardest case to reach from the ports is one where the two flag groups disagree. Only then does a wrong group choice change `wr_en`. The stimulus applies opposite Z values to the two groups and uses both legal selects, so that exactly one of the two selects gives a write. Register-mode vectors put ones in the ignored bits 10..5, so any leak of those bits into `wr_data` shows up.

// File: rtl/flagmove_unit.sv
module flagmove_unit #(
  parameter int XLEN = 64,
  parameter int IMMW = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [31:0]     instr,
  input  logic [3:0]      flags_narrow,
  input  logic [3:0]      flags_wide,
  input  logic [XLEN-1:0] src_val,
  output logic            out_valid,
  output logic            wr_en,
  output logic [4:0]      wr_idx,
  output logic [XLEN-1:0] wr_data,
  output logic            illegal
);
  localparam int EXTW = XLEN - IMMW;

  logic       is_mine;
  logic [2:0] ccsel;
  logic       sel_ok;
  logic [3:0] fl;
  logic       n, z, v, c;
  logic       base, hit;
  logic [XLEN-1:0] operand;

  assign is_mine = (instr[31:30] == 2'b10) && (instr[24:19] == 6'b101100);
  assign ccsel   = {instr[18], instr[12], instr[11]};
  assign sel_ok  = (ccsel == 3'b100) || (ccsel == 3'b110);
  assign fl      = ccsel[1] ? flags_wide : flags_narrow;
  assign {n, z, v, c} = fl;

  always_comb begin
    case (instr[16:14])
      3'd0:    base = 1'b0;
      3'd1:    base = z;
      3'd2:    base = z | (n ^ v);
      3'd3:    base = n ^ v;
      3'd4:    base = c | z;
      3'd5:    base = c;
      3'd6:    base = n;
      default: base = v;
    endcase
  end

  assign hit     = base ^ instr[17];
  assign operand = instr[13] ? {{EXTW{instr[IMMW-1]}}, instr[IMMW-1:0]} : src_val;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      wr_en     <= 1'b0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      wr_en     <= in_valid && is_mine && sel_ok && hit && (instr[29:25] != 5'd0);
      illegal   <= in_valid && is_mine && !sel_ok;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      wr_idx  <= instr[29:25];
      wr_data <= operand;
    end
  end
endmodule

// File: rtl/flagmove_unit_chk.sv
module flagmove_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       out_valid,
  input logic       wr_en,
  input logic [4:0] wr_idx,
  input logic       illegal
);
  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R1
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R4
  illegal_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !wr_en);
  // R9
  zero_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_idx != 5'd0));
  // R1
  write_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || illegal) |-> out_valid);
endmodule

bind flagmove_unit flagmove_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .wr_en(wr_en), .wr_idx(wr_idx), .illegal(illegal)
);

// File: tb/flagmove_unit_bench.sv
module flagmove_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [3:0]  flags_narrow = '0, flags_wide = '0;
  logic [63:0] src_val = 64'h0123_4567_89AB_CDEF;
  logic        out_valid, wr_en, illegal;
  logic [4:0]  wr_idx;
  logic [63:0] wr_data;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  flagmove_unit u_flagmove_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .flags_narrow(flags_narrow), .flags_wide(flags_wide), .src_val(src_val),
    .out_valid(out_valid), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .illegal(illegal)
  );

  // fields: [17:15] select, [14:11] cond, [10] imm, [9:6] narrow, [5:2] wide, [1] we, [0] illegal
  localparam logic [17:0] VEC [23] = '{
    {3'd4, 4'b0000, 1'b0, 4'hF, 4'h0, 1'b0, 1'b0},
    {3'd4, 4'b1000, 1'b1, 4'h0, 4'h0, 1'b1, 1'b0},
    {3'd4, 4'b0001, 1'b0, 4'h4, 4'h0, 1'b1, 1'b0},
    {3'd4, 4'b0001, 1'b1, 4'h0, 4'h0, 1'b0, 1'b0},
    {3'd4, 4'b1001, 1'b0, 4'h0, 4'h0, 1'b1, 1'b0},
    {3'd4, 4'b0010, 1'b1, 4'h8, 4'h0, 1'b1, 1'b0},
    {3'd4, 4'b1010, 1'b0, 4'hA, 4'h0, 1'b1, 1'b0},
    {3'd4, 4'b0011, 1'b1, 4'h2, 4'h0, 1'b1, 1'b0},
    {3'd4, 4'b1011, 1'b0, 4'h2, 4'h0, 1'b0, 1'b0},
    {3'd4, 4'b0100, 1'b1, 4'h1, 4'h0, 1'b1, 1'b0},
    {3'd4, 4'b1100, 1'b0, 4'h0, 4'h0, 1'b1, 1'b0},
    {3'd4, 4'b0101, 1'b1, 4'h0, 4'h0, 1'b0, 1'b0},
    {3'd4, 4'b1101, 1'b0, 4'h0, 4'h0, 1'b1, 1'b0},
    {3'd4, 4'b0110, 1'b1, 4'h8, 4'h0, 1'b1, 1'b0},
    {3'd4, 4'b1110, 1'b0, 4'h8, 4'h0, 1'b0, 1'b0},
    {3'd4, 4'b0111, 1'b1, 4'h2, 4'h0, 1'b1, 1'b0},
    {3'd4, 4'b1111, 1'b0, 4'h2, 4'h0, 1'b0, 1'b0},
    {3'd6, 4'b0001, 1'b0, 4'h0, 4'h4, 1'b1, 1'b0},
    {3'd6, 4'b0001, 1'b1, 4'h4, 4'h0, 1'b0, 1'b0},
    {3'd4, 4'b0001, 1'b0, 4'h4, 4'h0, 1'b1, 1'b0},
    {3'd0, 4'b1000, 1'b0, 4'h0, 4'h0, 1'b0, 1'b1},
    {3'd7, 4'b1000, 1'b1, 4'h0, 4'h0, 1'b0, 1'b1},
    {3'd5, 4'b1000, 1'b0, 4'h0, 4'h0, 1'b0, 1'b1}
  };

  function automatic logic [31:0] mk(input logic [2:0] sel, input logic [3:0] cond,
                                     input logic imm, input logic [4:0] rd,
                                     input logic [10:0] low);
    return {2'b10, rd, 6'b101100, sel[2], cond, imm, sel[1], sel[0], low};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] w, input logic [3:0] fn, input logic [3:0] fw);
    @(negedge clk);
    in_valid = 1'b1; instr = w; flags_narrow = fn; flags_wide = fw;
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(!out_valid && !wr_en && !illegal, "R1 reset", {out_valid, wr_en, illegal}, 0);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < 23; i++) begin
      logic [17:0] e;
      logic [10:0] low;
      e = VEC[i];
      low = e[10] ? 11'h7F0 : 11'h7E9;
      apply(mk(e[17:15], e[14:11], e[10], 5'd7, low), e[9:6], e[5:2]);
      chk(out_valid, "R1 valid", out_valid, 1);
      chk(wr_en == e[1], $sformatf("R5 R6 R3 R10 vec %0d we", i), wr_en, e[1]);
      chk(illegal == e[0], $sformatf("R4 vec %0d illegal", i), illegal, e[0]);
      chk(wr_idx == 5'd7, "R9 index", wr_idx, 7);
      if (e[1]) begin
        if (e[10]) chk(wr_data == 64'hFFFF_FFFF_FFFF_FFF0, "R8 imm", wr_data, 64'hFFFF_FFFF_FFFF_FFF0);
        else chk(wr_data == src_val, "R7 reg ignored bits", wr_data, src_val);
      end
    end

    apply(mk(3'd4, 4'b1000, 1'b1, 5'd0, 11'h001), 4'h0, 4'h0);
    chk(!wr_en, "R9 rd zero", wr_en, 0);
    apply({2'b11, mk(3'd4, 4'b1000, 1'b0, 5'd3, 11'h0)} [31:0] | 32'hC000_0000, 4'h0, 4'h0);
    chk(!wr_en && !illegal, "R2 top bits", {wr_en, illegal}, 0);
    apply(mk(3'd0, 4'b1000, 1'b0, 5'd3, 11'h0) ^ 32'h0008_0000, 4'h0, 4'h0);
    chk(!wr_en && !illegal, "R2 op3", {wr_en, illegal}, 0);
    apply(mk(3'd6, 4'b1000, 1'b1, 5'd31, 11'h3FF), 4'h0, 4'h0);
    chk(wr_en && wr_idx == 5'd31, "R9 index 31", {wr_en, wr_idx}, {1'b1, 5'd31});
    chk(wr_data == 64'h3FF, "R8 positive imm", wr_data, 64'h3FF);
    @(negedge clk); @(posedge clk); #1;
    chk(!out_valid && !wr_en && !illegal, "R1 idle", {out_valid, wr_en, illegal}, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule